// File: doc/BRIEF.md
# Privilege-Masked Interrupt Enable and Pending Registers

This block holds the interrupt-enable word and the interrupt-pending word of one hart. It also serves the narrower views of those two words that less privileged software sees. There is one physical copy of each word. A view selector on the register-access port chooses a fixed mask. A read returns the stored value ANDed with that mask. A write, set or clear can only change bits that lie inside the mask. Hardware pending lines from the timers and from the external interrupt controller feed the pending word directly. Software cannot overwrite those bits.

The low twelve bits are split into three groups of four: software interrupts, timer interrupts and external interrupts. Inside each group the privilege levels run upward: user, supervisor, hypervisor, machine. Downstream trap logic uses the combinational `irq_active` vector, which is pending AND enable over those twelve bits.

The asynchronous reset is released through a two-stage synchronizer. The registers therefore leave reset two clock edges after `rst_n` rises.

Top module: `irq_csr_alias`

## Requirements
- R1: After reset the enable word is zero, and every software-writable pending bit (bits 3:0) is zero.
- R2: Bit layout: bits 3:0 are software, bits 7:4 are timer and bits 11:8 are external interrupts. Within each group, bit offsets 0, 1, 2 and 3 belong to user, supervisor, hypervisor and machine.
- R3: The machine view (`csr_view`=3) uses an all-ones mask. Every bit of the XLEN-wide enable word can be set and cleared through it, including the machine external enable at bit 11.
- R4: The hypervisor view (`csr_view`=2) uses mask 0x777, the supervisor view (1) uses 0x333 and the user view (0) uses 0x111. A read through a view returns the stored value ANDed with that view's mask.
- R5: A write through any view leaves every bit outside that view's mask unchanged.
- R6: All views alias the same storage. A change made through one view is visible through every view whose mask covers the bit.
- R7: `csr_op` encoding: 0 is read only (no change), 1 is write, 2 is set bits and 3 is clear bits. The new value is (old & ~m) | (r & m). Here r is the write data, old|data or old&~data, and m is the effective write mask. `csr_reg` chooses the word: 0 for enable, 1 for pending. Nothing changes while `csr_en` is 0.
- R8: Pending bits 7:4 equal `hw_timer_irq` and pending bits 11:8 equal `hw_ext_irq` in the same cycle. Software writes to these bits have no effect.
- R9: Software pending bits 3:0 can be written through each view, restricted by that view's mask.
- R10: `irq_active` equals pending[11:0] AND enable[11:0], combinationally.
- R11: Pending bits above bit 11 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_view | input | 2 | View: 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| csr_reg | input | 1 | Word select: 0 enable, 1 pending |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | XLEN | Write / set / clear operand |
| hw_timer_irq | input | 4 | Timer pending lines, user..machine |
| hw_ext_irq | input | 4 | External controller pending lines, user..machine |
| csr_rdata | output | XLEN | Masked read data of the selected word |
| irq_active | output | 12 | Pending AND enable, low twelve bits |

## Verification
The bench builds the block with its default XLEN of 32. At that width the enable bits above the twelve interrupt bits exist. This shows that the machine view reaches them and that every narrower view hides and preserves them. The twelve-bit layout stays fixed, so every view mask, the hardware-only timer and external groups, and the writable software group can all be reached with full-word patterns. A long run of random view, operation, data and hardware-line combinations mixes aliasing and masking in every order.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  localparam int GROUP_W = 4;
  localparam int N_GROUPS = 3;
  localparam int IRQ_W = GROUP_W * N_GROUPS;

  typedef enum logic [1:0] {
    VIEW_U = 2'd0,
    VIEW_S = 2'd1,
    VIEW_H = 2'd2,
    VIEW_M = 2'd3
  } view_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // A bit is visible to a view when its privilege offset inside its group is
  // at or below the view's level.
  function automatic logic [IRQ_W-1:0] low_view_mask(input view_e v);
    logic [IRQ_W-1:0] m;
    for (int i = 0; i < IRQ_W; i++) begin
      m[i] = ((i % GROUP_W) <= int'(v));
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_view_mask.sv
module irq_view_mask
  import irq_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  view_e            view,
  output logic [XLEN-1:0]  mask
);
  localparam int HI_W = XLEN - IRQ_W;

  logic [IRQ_W-1:0] low_mask;

  always_comb begin
    low_mask = low_view_mask(view);
  end

  generate
    if (HI_W > 0) begin : g_wide
      always_comb begin
        mask = (view == VIEW_M) ? '1 : {{HI_W{1'b0}}, low_mask};
      end
    end else begin : g_narrow
      always_comb begin
        mask = (view == VIEW_M) ? '1 : low_mask;
      end
    end
  endgenerate

endmodule

// File: rtl/irq_csr_update.sv
module irq_csr_update
  import irq_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  op_e              op,
  input  logic [XLEN-1:0]  old_val,
  input  logic [XLEN-1:0]  operand,
  input  logic [XLEN-1:0]  wmask,
  output logic [XLEN-1:0]  new_val
);
  logic [XLEN-1:0] raw;

  always_comb begin
    unique case (op)
      OP_WRITE: raw = operand;
      OP_SET:   raw = old_val | operand;
      OP_CLEAR: raw = old_val & ~operand;
      default:  raw = old_val;
    endcase
    new_val = (old_val & ~wmask) | (raw & wmask);
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [XLEN-1:0]  d,
  output logic [XLEN-1:0]  q
);
  logic [XLEN-1:0] q_next;

  always_comb begin
    q_next = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R7: without a load the word must hold
  a_r7_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> q == $past(q));

endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int SW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SW_W-1:0]  d,
  output logic [SW_W-1:0]  q
);
  logic [SW_W-1:0] q_next;

  always_comb begin
    q_next = load ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  // R1: first cycle out of reset sees cleared software pending bits
  a_r1_sw_pend_cleared: assert property (@(posedge clk)
    $rose(rst_n) |-> q == '0);

endmodule

// File: rtl/irq_csr_alias.sv
module irq_csr_alias
  import irq_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_en,
  input  logic [1:0]        csr_view,
  input  logic              csr_reg,
  input  logic [1:0]        csr_op,
  input  logic [XLEN-1:0]   csr_wdata,
  input  logic [3:0]        hw_timer_irq,
  input  logic [3:0]        hw_ext_irq,
  output logic [XLEN-1:0]   csr_rdata,
  output logic [IRQ_W-1:0]  irq_active
);
  localparam int SW_W = GROUP_W;
  localparam int PAD_W = XLEN - IRQ_W;
  localparam logic [XLEN-1:0] SW_BITS = XLEN'((1 << SW_W) - 1);

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q;
  logic rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  view_e           view;
  op_e             op;
  logic [XLEN-1:0] vmask;
  logic [XLEN-1:0] wmask;
  logic [XLEN-1:0] en_q;
  logic [SW_W-1:0] sw_q;
  logic [XLEN-1:0] pend_vec;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;
  logic            wr_access;
  logic            en_load;
  logic            pend_load;

  always_comb begin
    view = view_e'(csr_view);
    op   = op_e'(csr_op);
  end

  irq_view_mask #(.XLEN(XLEN)) u_mask (
    .view (view),
    .mask (vmask)
  );

  always_comb begin
    pend_vec  = {{PAD_W{1'b0}}, hw_ext_irq, hw_timer_irq, sw_q};
    old_val   = csr_reg ? pend_vec : en_q;
    wmask     = csr_reg ? (vmask & SW_BITS) : vmask;
    wr_access = csr_en && (op != OP_READ);
    en_load   = wr_access && !csr_reg;
    pend_load = wr_access && csr_reg;
  end

  irq_csr_update #(.XLEN(XLEN)) u_update (
    .op      (op),
    .old_val (old_val),
    .operand (csr_wdata),
    .wmask   (wmask),
    .new_val (new_val)
  );

  irq_enable_reg #(.XLEN(XLEN)) u_enable (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (en_load),
    .d     (new_val),
    .q     (en_q)
  );

  irq_pending_reg #(.SW_W(SW_W)) u_pending (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (pend_load),
    .d     (new_val[SW_W-1:0]),
    .q     (sw_q)
  );

  always_comb begin
    csr_rdata  = old_val & vmask;
    irq_active = pend_vec[IRQ_W-1:0] & en_q[IRQ_W-1:0];
  end

  // R5: enable bits outside the view mask survive any access
  a_r5_outside_mask_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
    (csr_en && !csr_reg) |=> ((en_q & ~$past(vmask)) == ($past(en_q) & ~$past(vmask))));

  // R7: a read-only access changes neither word
  a_r7_read_no_change: assert property (@(posedge clk) disable iff (!rst_int_n)
    (csr_en && csr_op == 2'd0) |=> (en_q == $past(en_q) && sw_q == $past(sw_q)));

  // R8: external pending bits track the controller lines, as seen at the read port
  a_r8_ext_follows_hw: assert property (@(posedge clk) disable iff (!rst_int_n)
    (csr_reg && csr_view == 2'd3) |-> csr_rdata[11:8] == hw_ext_irq);

  // R10: an active interrupt is always enabled
  a_r10_active_enabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_active & ~en_q[IRQ_W-1:0]) == '0);

  // R4: narrow views never expose bits above the interrupt field
  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (csr_view != 2'd3) |-> (csr_rdata >> IRQ_W) == '0);

endmodule

// File: tb/irq_csr_alias_tb_top.sv
module irq_csr_alias_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            csr_en = 1'b0;
  logic [1:0]      csr_view = 2'd3;
  logic            csr_reg = 1'b0;
  logic [1:0]      csr_op = 2'd0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [3:0]      hw_timer_irq = '0;
  logic [3:0]      hw_ext_irq = '0;
  logic [XLEN-1:0] csr_rdata;
  logic [11:0]     irq_active;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [XLEN-1:0] m_en;
  logic [3:0]      m_sw;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_csr_alias #(.XLEN(XLEN)) dut_i (
    .clk (clk), .rst_n (rst_n), .csr_en (csr_en), .csr_view (csr_view),
    .csr_reg (csr_reg), .csr_op (csr_op), .csr_wdata (csr_wdata),
    .hw_timer_irq (hw_timer_irq), .hw_ext_irq (hw_ext_irq),
    .csr_rdata (csr_rdata), .irq_active (irq_active)
  );

  function automatic logic [XLEN-1:0] view_mask(input logic [1:0] v);
    case (v)
      2'd0: return 32'h0000_0111;
      2'd1: return 32'h0000_0333;
      2'd2: return 32'h0000_0777;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] pend_word();
    return {20'h0, hw_ext_irq, hw_timer_irq, m_sw};
  endfunction

  task automatic step(input logic en, input logic [1:0] v, input logic r,
                      input logic [1:0] op, input logic [XLEN-1:0] wd,
                      input string tag);
    logic [XLEN-1:0] old, raw, wm, nv, exp_rd;
    logic [11:0]     exp_act;
    csr_en = en; csr_view = v; csr_reg = r; csr_op = op; csr_wdata = wd;
    #(CLK_PERIOD/4);
    old     = r ? pend_word() : m_en;
    exp_rd  = old & view_mask(v);
    exp_act = pend_word()[11:0] & m_en[11:0];
    vectors++;
    if (csr_rdata !== exp_rd || irq_active !== exp_act) begin
      miscompares++;
      $display("FAIL %s: rdata=%h active=%h expected rdata=%h active=%h",
               tag, csr_rdata, irq_active, exp_rd, exp_act);
    end
    @(posedge clk);
    if (en && op != 2'd0) begin
      case (op)
        2'd1: raw = wd;
        2'd2: raw = old | wd;
        default: raw = old & ~wd;
      endcase
      wm = r ? (view_mask(v) & 32'hF) : view_mask(v);
      nv = (old & ~wm) | (raw & wm);
      if (r) m_sw = nv[3:0];
      else   m_en = nv;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    m_en = '0; m_sw = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state of both words
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R1");
    step(1'b0, 2'd3, 1'b1, 2'd0, '0, "R1");
    // R3 machine external enable bit 11 set, then cleared
    step(1'b1, 2'd3, 1'b0, 2'd1, 32'h800, "R3");
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R3");
    step(1'b1, 2'd3, 1'b0, 2'd3, 32'h800, "R3");
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R3");
    step(1'b1, 2'd3, 1'b0, 2'd1, 32'hFFFF_FFFF, "R3");
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R3");
    // R4 each narrower view of an all-ones word
    for (int v = 0; v < 3; v++) step(1'b0, 2'(v), 1'b0, 2'd0, '0, "R4");
    // R5 supervisor write of zero leaves outside bits
    step(1'b1, 2'd1, 1'b0, 2'd1, 32'h0, "R5");
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R5");
    // R6 supervisor clears then sets its external enable, machine view sees it
    step(1'b1, 2'd3, 1'b0, 2'd1, 32'h0, "R6");
    step(1'b1, 2'd1, 1'b0, 2'd2, 32'h200, "R6");
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R6");
    step(1'b0, 2'd0, 1'b0, 2'd0, '0, "R6");
    // R7 disabled write and read-only op do nothing
    step(1'b0, 2'd3, 1'b0, 2'd1, 32'hFFF, "R7");
    step(1'b1, 2'd3, 1'b0, 2'd0, 32'hFFF, "R7");
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R7");
    // R8 hardware-only pending groups ignore software writes
    hw_ext_irq = 4'b1000; hw_timer_irq = 4'b0010;
    step(1'b1, 2'd3, 1'b1, 2'd1, 32'h0, "R8");
    step(1'b0, 2'd3, 1'b1, 2'd0, '0, "R8");
    hw_ext_irq = 4'b0000; hw_timer_irq = 4'b0000;
    step(1'b1, 2'd3, 1'b1, 2'd1, 32'hFFFF_FFFF, "R8");
    // R11 upper pending bits stay zero
    step(1'b0, 2'd3, 1'b1, 2'd0, '0, "R11");
    // R9 user view clears only its own software bit
    step(1'b1, 2'd0, 1'b1, 2'd3, 32'hF, "R9");
    step(1'b0, 2'd3, 1'b1, 2'd0, '0, "R9");
    // R10 active vector
    step(1'b1, 2'd3, 1'b0, 2'd1, 32'hAAA, "R10");
    hw_ext_irq = 4'b1010; hw_timer_irq = 4'b1111;
    step(1'b0, 2'd3, 1'b0, 2'd0, '0, "R10");
    // R2 each group's machine bit lines up with its hardware line
    hw_timer_irq = 4'b1000; hw_ext_irq = 4'b0000;
    step(1'b0, 2'd3, 1'b1, 2'd0, '0, "R2");

    // random mix, R7 formula under every view and op
    for (int i = 0; i < 4000; i++) begin
      hw_timer_irq = 4'($urandom);
      hw_ext_irq   = 4'($urandom);
      step(1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
           $urandom, "R7");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule